// File: doc/BRIEF.md
# Single-Wire Bus Low-Duration Monitor

This block observes an open-drain single-wire bus, where the line idles high and a master starts every time slot by pulling it low. It only samples the line and never drives it. The sampled level first passes through a two-stage synchronizer. A small state machine then tracks each low period. It emits a one-cycle pulse when a slot begins and a one-cycle pulse when the line has stayed low long enough to count as a bus reset. It also shows whether the bus is idle.

The reset limit depends on the bus speed. Regular speed uses 120 µs and overdrive uses 16 µs. Both limits are converted to clock cycles from a clock-frequency parameter. The speed select is captured at each falling edge, so changing it in the middle of a low period has no effect on that period. A high period of any length leaves the monitor undisturbed, which allows a paused transaction to resume.

The state machine has three states:
- `ST_IDLE` means the line is high. It moves to `ST_LOW` on a synchronized low sample; this is the falling edge.
- `ST_LOW` counts low cycles. It returns to `ST_IDLE` when the line is high. It moves to `ST_FLAGGED` when the count crosses the limit.
- `ST_FLAGGED` waits out the rest of a reset-length low. It returns to `ST_IDLE` when the line is high.

Top module: `swire_low_monitor`

## Requirements
- R1: After synchronous reset, `bus_idle` is 1 and `slot_start` and `reset_seen` are 0.
- R2: Each high-to-low transition of `line_raw` produces exactly one `slot_start` pulse, one cycle wide. The pulse appears two clock cycles after the first clock edge that samples the line low, which is the synchronizer delay.
- R3: With regular speed captured (`fast_mode`=0), `reset_seen` pulses in the cycle of the (REG+1)-th consecutive synchronized low sample, where REG = CLK_HZ/1e6 × 120. A low lasting exactly REG cycles gives no pulse.
- R4: With overdrive captured (`fast_mode`=1), the same rule applies with FAST = CLK_HZ/1e6 × 16.
- R5: `fast_mode` is captured in the cycle of the falling edge and held for the whole low period. Changes to it during that low period have no effect.
- R6: `reset_seen` fires at most once per low period, however long the low lasts. The low-time counter saturates instead of wrapping.
- R7: `bus_idle` drops in the cycle after `slot_start`. It returns to 1 in the cycle after the first synchronized high sample.
- R8: A high period of any length produces no pulses and keeps `bus_idle` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_raw | input | 1 | Sampled bus level, asynchronous to clk |
| fast_mode | input | 1 | Speed select: 1 = overdrive, 0 = regular |
| slot_start | output | 1 | One-cycle pulse at each falling edge |
| reset_seen | output | 1 | One-cycle pulse when the low time crosses the limit |
| bus_idle | output | 1 | High while the bus is idle (line high) |

## Verification
The bench builds the block with CLK_HZ = 1,000,000, which gives limits of 120 and 16 cycles. At these values both thresholds and their one-off boundaries can be reached in a short run. A 400-cycle low drives the 7-bit counter into saturation, which shows that a wrapped counter cannot fire a second pulse. Mode flips in the middle of a low period and 2000-cycle high gaps are also covered.

// File: rtl/swm_pkg.sv
package swm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_FLAGGED = 2'd2
    } mon_state_t;

    // Whole microseconds converted to clock cycles.
    function automatic int us_to_cycles(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= IDLE_LEVEL;
            stage2 <= IDLE_LEVEL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign d_sync = stage2;
endmodule

// File: rtl/swm_low_counter.sv
module swm_low_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_one,
    input  logic         step,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_one) begin
            count <= W'(1);
        end else if (step && count != TOP) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/swm_ctrl.sv
module swm_ctrl
    import swm_pkg::*;
#(
    parameter int W        = 8,
    parameter int REG_CYC  = 120,
    parameter int FAST_CYC = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line_s,
    input  logic         fast_mode,
    input  logic [W-1:0] count,
    output logic         load_one,
    output logic         step,
    output logic         slot_start,
    output logic         reset_seen,
    output logic         bus_idle
);
    localparam logic [W-1:0] REG_LIM  = W'(REG_CYC);
    localparam logic [W-1:0] FAST_LIM = W'(FAST_CYC);

    mon_state_t state, nxt;
    logic       mode_q;
    logic [W-1:0] limit;

    assign limit = mode_q ? FAST_LIM : REG_LIM;

    // State register and captured speed mode.
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && !line_s)
                mode_q <= fast_mode;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (!line_s) nxt = ST_LOW;
            ST_LOW:     if (line_s) nxt = ST_IDLE;
                        else if (count >= limit) nxt = ST_FLAGGED;
            ST_FLAGGED: if (line_s) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        slot_start = 1'b0;
        reset_seen = 1'b0;
        load_one   = 1'b0;
        step       = 1'b0;
        bus_idle   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                bus_idle   = 1'b1;
                slot_start = !line_s;
                load_one   = !line_s;
            end
            ST_LOW: begin
                step       = !line_s;
                reset_seen = !line_s && (count >= limit);
            end
            ST_FLAGGED: step = !line_s;
            default: ;
        endcase
    end
endmodule

// File: rtl/swire_low_monitor.sv
module swire_low_monitor
    import swm_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int REG_US  = 120,
    parameter int FAST_US = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    input  logic fast_mode,
    output logic slot_start,
    output logic reset_seen,
    output logic bus_idle
);
    localparam int REG_CYC  = us_to_cycles(CLK_HZ, REG_US);
    localparam int FAST_CYC = us_to_cycles(CLK_HZ, FAST_US);
    localparam int MAX_CYC  = (REG_CYC > FAST_CYC) ? REG_CYC : FAST_CYC;
    localparam int CW       = $clog2(MAX_CYC + 2);

    logic          line_s, load_one, step;
    logic [CW-1:0] count;

    swm_sync #(.IDLE_LEVEL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d_async(line_raw), .d_sync(line_s)
    );

    swm_low_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .load_one(load_one), .step(step), .count(count)
    );

    swm_ctrl #(.W(CW), .REG_CYC(REG_CYC), .FAST_CYC(FAST_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .line_s(line_s), .fast_mode(fast_mode),
        .count(count), .load_one(load_one), .step(step),
        .slot_start(slot_start), .reset_seen(reset_seen), .bus_idle(bus_idle)
    );
endmodule

// File: rtl/swm_checker.sv
module swm_checker (
    input logic clk,
    input logic rst,
    input logic slot_start,
    input logic reset_seen,
    input logic bus_idle
);
    logic fired_q;

    always_ff @(posedge clk) begin
        if (rst) fired_q <= 1'b0;
        else if (slot_start) fired_q <= 1'b0;
        else if (reset_seen) fired_q <= 1'b1;
    end

    // R2
    slot_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !slot_start);
    // R2
    slot_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> bus_idle);
    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !bus_idle);
    // R3
    flag_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        reset_seen |-> !bus_idle);
    // R6
    flag_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        reset_seen |=> !reset_seen);
    // R6
    flag_once_chk: assert property (@(posedge clk) disable iff (rst)
        reset_seen |-> !fired_q);
endmodule

bind swire_low_monitor swm_checker u_chk (
    .clk(clk), .rst(rst), .slot_start(slot_start),
    .reset_seen(reset_seen), .bus_idle(bus_idle)
);

// File: tb/swire_low_monitor_test.sv
module swire_low_monitor_test;
    localparam int CLK_HZ = 1_000_000;
    localparam int REG_L  = 120;
    localparam int FAST_L = 16;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1, line_raw = 1'b1, fast_mode = 1'b0;
    logic slot_start, reset_seen, bus_idle;
    int   cyc = 0, checks = 0, errors = 0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    swire_low_monitor #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst(rst), .line_raw(line_raw), .fast_mode(fast_mode),
        .slot_start(slot_start), .reset_seen(reset_seen), .bus_idle(bus_idle)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Monitor: pop expected events and compare kind and cycle.
    task automatic take(input int kind);
        exp_t e;
        if (q.size() == 0) begin
            chk(1'b0, kind ? "R6 unexpected reset_seen" : "R2 unexpected slot_start", 1, 0);
        end else begin
            e = q.pop_front();
            chk(e.kind == kind && e.cyc == cyc, e.req, kind * 100000 + cyc,
                e.kind * 100000 + e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (slot_start) take(0);
            if (reset_seen) take(1);
        end
    end

    // Driver: one low period of len cycles, with optional mid-low mode flip.
    task automatic low_pulse(input int len, input bit fast, input bit flip, input string req);
        int c0, lim;
        @(negedge clk);
        c0 = cyc;
        line_raw  = 1'b0;
        fast_mode = fast;
        lim = fast ? FAST_L : REG_L;
        q.push_back('{0, c0 + 2, {"R2 slot ", req}});
        if (len > lim) q.push_back('{1, c0 + 2 + lim, {"R3/R4 flag ", req}});
        while (cyc < c0 + len) begin
            @(negedge clk);
            if (cyc == c0 + 3) chk(bus_idle == 1'b0, "R7 idle drop", bus_idle, 0);
            if (flip && cyc == c0 + 4) fast_mode = !fast;
        end
        line_raw = 1'b1;
        while (cyc < c0 + 3 + len) @(negedge clk);
        chk(bus_idle == 1'b1, "R7 idle return", bus_idle, 1);
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bus_idle == 1'b1, "R1 idle", bus_idle, 1);
        chk(slot_start == 1'b0, "R1 slot", slot_start, 0);
        chk(reset_seen == 1'b0, "R1 flag", reset_seen, 0);

        low_pulse(50, 1'b0, 1'b0, "R2 regular short");
        low_pulse(REG_L, 1'b0, 1'b0, "R3 exact limit");
        low_pulse(REG_L + 1, 1'b0, 1'b0, "R3 one over");
        low_pulse(FAST_L, 1'b1, 1'b0, "R4 exact limit");
        low_pulse(FAST_L + 1, 1'b1, 1'b0, "R4 one over");
        low_pulse(30, 1'b1, 1'b1, "R5 fast held");
        low_pulse(30, 1'b0, 1'b1, "R5 regular held");
        low_pulse(400, 1'b0, 1'b0, "R6 saturation");
        low_pulse(1, 1'b0, 1'b0, "R2 narrow a");
        low_pulse(1, 1'b1, 1'b0, "R2 narrow b");

        // R8 long high: no events, idle held
        repeat (2000) begin
            @(negedge clk);
            if (!bus_idle) chk(1'b0, "R8 idle during high", bus_idle, 1);
        end
        chk(bus_idle == 1'b1, "R8 idle after long high", bus_idle, 1);
        low_pulse(REG_L + 1, 1'b0, 1'b0, "R8 after pause");

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R2/R3 pending events", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule